// File: doc/BRIEF.md
# Carry-Select Wide Adder

This block adds two wide unsigned operands and a carry-in and produces the wide sum and a carry-out. It is purely combinational. The operand width is split into equal segments, each handled by its own narrow adder slice. The lowest segment is added once, using the external carry-in.

Every higher segment is added twice at the same time. One copy assumes an incoming carry of 0 and the other assumes an incoming carry of 1. The real carry leaving the segment below then picks which copy supplies the sum bits and the carry passed upward. Because of this, the long path is one slice add plus a chain of multiplexers, not a carry that ripples through the full width.

With the default parameters the 64-bit datapath is built from 32-bit slices. The upper half is computed speculatively, and the lower-half carry picks the result. Each slice is a separate instance, so the speculative structure stays visible in the hierarchy.

Top module: `csa_wide_adder`

## Requirements
- R1: For every input, {carry_out, sum_out} equals the full-width unsigned sum opnd_a + opnd_b + carry_in, taken as a WIDTH+1 bit value.
- R2: Bits [SLICE_W-1:0] of sum_out depend only on the low SLICE_W bits of both operands and on carry_in. Changing the upper operand bits leaves them unchanged.
- R3: A carry generated in the low segment reaches the next segment. With opnd_a = 0x00000000_FFFFFFFF, opnd_b = 1 and carry_in = 0, the result is sum_out = 0x00000001_00000000 with carry_out = 0.
- R4: With both operands all ones and carry_in = 1, sum_out is all ones and carry_out is 1.
- R5: With both operands zero and carry_in = 1, sum_out is 1 and carry_out is 0.
- R6: carry_in alone can ripple out of the low segment. With opnd_a = 0x00000000_FFFFFFFF, opnd_b = 0 and carry_in = 1, the result is sum_out = 0x00000001_00000000.
- R7: A carry can leave the full width. With opnd_a all ones, opnd_b = 0 and carry_in = 1, sum_out is 0 and carry_out is 1.
- R8: When the low segment produces no carry, the upper bits and carry_out come from the carry-0 copy. With opnd_a = 0xFFFFFFFF_00000000, opnd_b = 0 and carry_in = 0, sum_out equals opnd_a and carry_out is 0.
- R9: The result in R1 holds for any SLICE_W that divides WIDTH. This includes more than two segments, where the select carries form a chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First unsigned operand |
| opnd_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench builds two copies side by side. The first uses the default 64-bit width with 32-bit slices, which gives one speculative pair chosen by a single carry. The second uses 64 bits with 16-bit slices, which gives three speculative pairs in a chained selection, so that carries crossing bits 15, 31 and 47 are exercised as well. Both copies receive the same directed corner vectors and random vectors, including low segments forced to all ones, and are compared against a 65-bit reference sum.

// File: rtl/csa_pkg.sv
package csa_pkg;
    localparam int CSA_DEF_WIDTH = 64;
    localparam int CSA_DEF_SLICE = 32;

    function automatic int csa_seg_count(input int width, input int slice_w);
        return width / slice_w;
    endfunction
endpackage

// File: rtl/csa_slice.sv
module csa_slice #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         c_in,
    output logic [W-1:0] s_out,
    output logic         c_out
);
    logic [W:0] total_d;

    always_comb begin
        total_d = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, c_in};
    end

    assign s_out = total_d[W-1:0];
    assign c_out = total_d[W];
endmodule

// File: rtl/csa_spec_stage.sv
module csa_spec_stage #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         sel_carry,
    output logic [W-1:0] s_out,
    output logic         c_out
);
    logic [W-1:0] sum_c0_d, sum_c1_d;
    logic         cy_c0_d, cy_c1_d;

    // copy that assumes no incoming carry
    csa_slice #(.W(W)) slice_c0_i (
        .a_in (a_in),
        .b_in (b_in),
        .c_in (1'b0),
        .s_out(sum_c0_d),
        .c_out(cy_c0_d)
    );

    // copy that assumes an incoming carry
    csa_slice #(.W(W)) slice_c1_i (
        .a_in (a_in),
        .b_in (b_in),
        .c_in (1'b1),
        .s_out(sum_c1_d),
        .c_out(cy_c1_d)
    );

    always_comb begin
        if (sel_carry) begin
            s_out = sum_c1_d;
            c_out = cy_c1_d;
        end else begin
            s_out = sum_c0_d;
            c_out = cy_c0_d;
        end
    end
endmodule

// File: rtl/csa_wide_adder.sv
module csa_wide_adder #(
    parameter int WIDTH   = csa_pkg::CSA_DEF_WIDTH,
    parameter int SLICE_W = csa_pkg::CSA_DEF_SLICE
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    localparam int NSEG = csa_pkg::csa_seg_count(WIDTH, SLICE_W);

    // seg_cy_d[k] is the real carry entering segment k
    logic [NSEG:0] seg_cy_d;

    assign seg_cy_d[0] = carry_in;

    csa_slice #(.W(SLICE_W)) low_slice_i (
        .a_in (opnd_a[SLICE_W-1:0]),
        .b_in (opnd_b[SLICE_W-1:0]),
        .c_in (seg_cy_d[0]),
        .s_out(sum_out[SLICE_W-1:0]),
        .c_out(seg_cy_d[1])
    );

    for (genvar g = 1; g < NSEG; g++) begin : g_spec
        csa_spec_stage #(.W(SLICE_W)) stage_i (
            .a_in     (opnd_a[g*SLICE_W +: SLICE_W]),
            .b_in     (opnd_b[g*SLICE_W +: SLICE_W]),
            .sel_carry(seg_cy_d[g]),
            .s_out    (sum_out[g*SLICE_W +: SLICE_W]),
            .c_out    (seg_cy_d[g+1])
        );
    end

    assign carry_out = seg_cy_d[NSEG];
endmodule

// File: rtl/csa_wide_adder_chk.sv
module csa_wide_adder_chk #(
    parameter int WIDTH   = 64,
    parameter int SLICE_W = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out
);
    logic [WIDTH:0]   full_ref;
    logic [SLICE_W:0] low_ref;
    logic             known;

    always_comb begin
        known    = !$isunknown({opnd_a, opnd_b, carry_in});
        full_ref = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
        low_ref  = {1'b0, opnd_a[SLICE_W-1:0]} + {1'b0, opnd_b[SLICE_W-1:0]}
                 + {{SLICE_W{1'b0}}, carry_in};
        if (known) begin
            a_r1_full_sum: assert ({carry_out, sum_out} == full_ref)
                else $error("R1 wide sum mismatch");
            a_r2_low_segment: assert (sum_out[SLICE_W-1:0] == low_ref[SLICE_W-1:0])
                else $error("R2 low segment mismatch");
            a_r4_all_ones: assert (!(&opnd_a && &opnd_b && carry_in) || (&sum_out && carry_out))
                else $error("R4 all-ones case");
            a_r5_zero_plus_cin: assert (!(opnd_a == '0 && opnd_b == '0 && carry_in)
                                        || (sum_out == WIDTH'(1) && !carry_out))
                else $error("R5 zero plus carry");
            a_r7_wrap: assert (!(&opnd_a && opnd_b == '0 && carry_in) || (sum_out == '0 && carry_out))
                else $error("R7 full wrap");
        end
    end
endmodule

bind csa_wide_adder csa_wide_adder_chk #(.WIDTH(WIDTH), .SLICE_W(SLICE_W)) chk_i (.*);

// File: tb/csa_wide_adder_tb_top.sv
module csa_wide_adder_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [63:0] a_v, b_v;
    logic        cin_v;
    logic [63:0] sum_h, sum_q;
    logic        cy_h, cy_q;
    int          n_vec  = 0;
    int          n_fail = 0;

    csa_wide_adder dut_i (
        .opnd_a(a_v), .opnd_b(b_v), .carry_in(cin_v),
        .sum_out(sum_h), .carry_out(cy_h)
    );

    csa_wide_adder #(.WIDTH(64), .SLICE_W(16)) dut_q4 (
        .opnd_a(a_v), .opnd_b(b_v), .carry_in(cin_v),
        .sum_out(sum_q), .carry_out(cy_q)
    );

    task automatic compare(input string req, input logic [64:0] got, input logic [64:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic apply(input string req, input logic [63:0] a, input logic [63:0] b, input logic c);
        logic [64:0] ref_sum;
        @(posedge clk);
        #1;
        a_v = a; b_v = b; cin_v = c;
        ref_sum = {1'b0, a} + {1'b0, b} + {64'd0, c};
        @(negedge clk);
        compare(req, {cy_h, sum_h}, ref_sum);
        compare({req, "/R9"}, {cy_q, sum_q}, ref_sum);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] ra, rb;
        logic [31:0] lo_fix;
        a_v = '0; b_v = '0; cin_v = 1'b0;
        @(negedge clk);
        compare("R1 reset-state zero", {cy_h, sum_h}, 65'd0);

        apply("R3", 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0);
        compare("R3 directed", {cy_h, sum_h}, {1'b0, 64'h0000_0001_0000_0000});
        apply("R4", '1, '1, 1'b1);
        compare("R4 directed", {cy_h, sum_h}, {1'b1, {64{1'b1}}});
        apply("R5", '0, '0, 1'b1);
        compare("R5 directed", {cy_h, sum_h}, 65'd1);
        apply("R6", 64'h0000_0000_FFFF_FFFF, 64'd0, 1'b1);
        compare("R6 directed", {cy_h, sum_h}, {1'b0, 64'h0000_0001_0000_0000});
        apply("R7", '1, '0, 1'b1);
        compare("R7 directed", {cy_h, sum_h}, {1'b1, 64'd0});
        apply("R8", 64'hFFFF_FFFF_0000_0000, 64'd0, 1'b0);
        compare("R8 directed", {cy_h, sum_h}, {1'b0, 64'hFFFF_FFFF_0000_0000});
        apply("R1 carry at 15", 64'h0000_0000_0000_FFFF, 64'd1, 1'b0);
        apply("R1 carry at 47", 64'h0000_FFFF_FFFF_FFFF, 64'd0, 1'b1);
        apply("R1 hi-only", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);

        // R2: fixed low operands, varying upper operands
        lo_fix = $urandom;
        for (int i = 0; i < 20; i++) begin
            ra = {$urandom, lo_fix};
            rb = {$urandom, 32'h1234_5678};
            apply("R2", ra, rb, 1'b1);
            compare("R2 low bits", {33'd0, sum_h[31:0]},
                    {33'd0, lo_fix + 32'h1234_5678 + 32'd1});
        end

        for (int i = 0; i < 300; i++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (i % 4 == 1) ra[31:0] = 32'hFFFF_FFFF;
            if (i % 4 == 2) begin ra[15:0] = 16'hFFFF; rb[15:0] = 16'h0000; end
            if (i % 4 == 3) rb = ~ra;
            apply("R1 random", ra, rb, 1'(i % 2));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule